// File: doc/BRIEF.md
# Receive Error Event Tally

This block keeps three small event tallies for a receive datapath: frames that failed the CRC check, frames that ended off a byte boundary, and frames dropped because no buffer space was available. The datapath raises one single-cycle event input per occurrence. Each tally is 4 bits wide and holds the number of events since software last looked at it. Reading a tally through the 32-bit register port returns its value and empties it in the same cycle.

Software learns that it polled too slowly through a sticky overflow flag. The flag is set whenever any tally steps from 15 back to 0. It appears on an output pin and in bit 9 of a status word. Software clears it by writing a one to that bit. Event detection, frame parsing and the rest of the interrupt logic live outside this block.

Top module: `rxerr_tally`

## Requirements
- R1: After reset, all three tallies read 0, the overflow flag is 0 and `rd_data` is 0.
- R2: Each pulse on an event input adds one, modulo 16, to its own tally only. `ev_crc` maps to byte offset 0x20, `ev_align` to 0x24 and `ev_miss` to 0x28.
- R3: A read at a tally offset puts that tally's value on `rd_data[3:0]` in the cycle after `rd_en` and clears the tally to 0.
- R4: When an event and a read of the same tally fall in one cycle, the read returns the old value and the tally becomes 1. This does not count as a wrap, even when the old value is 15.
- R5: A tally stepping from 15 to 0 on an event sets the overflow flag. The flag is visible on `ovf_irq` and as bit 9 of the status word at byte offset 0x04.
- R6: The flag stays set until a write to offset 0x04 with bit 9 of `wr_data` equal to 1. A write with bit 9 equal to 0, or a write to any other offset, leaves the flag unchanged.
- R7: If a wrap and a clearing write happen in the same cycle, the flag ends up set.
- R8: Bits 31..4 of a tally read are 0. Every status-word bit other than bit 9 is 0. An unmapped offset reads as 0. Reading the status word clears nothing.
- R9: Events on all three inputs in the same cycle are each counted in their own tally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_crc | input | 1 | One pulse per frame with a CRC error |
| ev_align | input | 1 | One pulse per frame with an alignment error |
| ev_miss | input | 1 | One pulse per frame missed for lack of buffers |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data; bit 9 at 0x04 clears the flag |
| ovf_irq | output | 1 | Sticky overflow flag |

## Verification
Two pairs of operations can land on the same clock edge. The first pair is an event and the read that empties the same tally. The second is a wrap and the host write that clears the flag. The bench provokes both by raising the event input on the same falling edge as the read or write strobe. For the first pair it checks the returned old value and then a follow-up read of exactly 1; this is done at 5 and again at 15, where no flag may appear. For the second pair it requires the flag to still be set after the edge.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int unsigned REG_AW   = 8;
  localparam int unsigned REG_DW   = 32;
  localparam int unsigned TALLY_W  = 4;
  localparam int unsigned N_TALLY  = 3;
  localparam logic [REG_AW-1:0] TALLY_BASE = 8'h20;
  localparam logic [REG_AW-1:0] STAT_OFS   = 8'h04;
  localparam int unsigned OVF_BIT  = 9;
  localparam int unsigned IDX_CRC   = 0;
  localparam int unsigned IDX_ALIGN = 1;
  localparam int unsigned IDX_MISS  = 2;
endpackage

// File: rtl/rxerr_cnt.sv
module rxerr_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         rd_clr,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ev | rd_clr;
    cnt_d  = cnt_q;
    if (rd_clr) begin
      cnt_d = ev ? CNT_ONE : '0;
    end else if (ev) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = ev & ~rd_clr & (cnt_q == CNT_MAX);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !rd_clr) |=> (cnt == $past(cnt) + CNT_ONE)); // R2
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !rd_clr) |=> $stable(cnt)); // R2
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !ev) |=> (cnt == '0)); // R3
  AST_RD_AND_EV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev) |=> (cnt == CNT_ONE)); // R4
endmodule

// File: rtl/rxerr_ovf.sv
module rxerr_ovf #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap,
  input  logic         clr_req,
  output logic         flag
);
  logic flag_q, flag_d, set_any;

  always_comb begin
    set_any = |wrap;
    flag_d  = flag_q;
    if (set_any) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> flag); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R6
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(|wrap)) |=> !flag); // R6
  AST_OVF_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !(|wrap)) |=> !flag); // R5
endmodule

// File: rtl/rxerr_rdmux.sv
module rxerr_rdmux
  import rxerr_pkg::*;
#(
  parameter int unsigned N  = N_TALLY,
  parameter int unsigned W  = TALLY_W,
  parameter int unsigned AW = REG_AW,
  parameter int unsigned DW = REG_DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  input  logic [N-1:0][W-1:0] cnts,
  input  logic                flag,
  output logic [N-1:0]        rd_clr,
  output logic [DW-1:0]       rd_data
);
  logic [N-1:0]  hit;
  logic          stat_hit;
  logic [DW-1:0] data_d, data_q;

  for (genvar i = 0; i < N; i++) begin : g_dec
    localparam logic [AW-1:0] OFS = AW'(TALLY_BASE + AW'(4 * i));
    assign hit[i]    = (rd_addr == OFS);
    assign rd_clr[i] = rd_en & hit[i];
  end

  assign stat_hit = (rd_addr == STAT_OFS);

  always_comb begin
    data_d = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        data_d[W-1:0] = cnts[i];
      end
    end
    if (stat_hit) begin
      data_d[OVF_BIT] = flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_en) begin
      data_q <= data_d;
    end
  end

  assign rd_data = data_q;

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_clr)); // R3
  AST_TALLY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_clr) |=> (rd_data[DW-1:W] == '0)); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R3
  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_RD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr[i] |=> (rd_data[W-1:0] == $past(cnts[i]))); // R3
  end
endmodule

// File: rtl/rxerr_tally.sv
module rxerr_tally
  import rxerr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_crc,
  input  logic              ev_align,
  input  logic              ev_miss,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              ovf_irq
);
  logic [N_TALLY-1:0]              ev_vec;
  logic [N_TALLY-1:0]              clr_vec;
  logic [N_TALLY-1:0]              wrap_vec;
  logic [N_TALLY-1:0][TALLY_W-1:0] cnt_vec;
  logic                            flag_clr;
  logic                            flag;
  logic                            unused_wr_bits;

  assign ev_vec[IDX_CRC]   = ev_crc;
  assign ev_vec[IDX_ALIGN] = ev_align;
  assign ev_vec[IDX_MISS]  = ev_miss;

  for (genvar i = 0; i < N_TALLY; i++) begin : g_tally
    rxerr_cnt #(.W(TALLY_W)) i_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_vec[i]),
      .rd_clr (clr_vec[i]),
      .cnt    (cnt_vec[i]),
      .wrap   (wrap_vec[i])
    );
  end

  assign flag_clr       = wr_en & (wr_addr == STAT_OFS) & wr_data[OVF_BIT];
  assign unused_wr_bits = ^{wr_data[REG_DW-1:OVF_BIT+1], wr_data[OVF_BIT-1:0]};

  rxerr_ovf #(.N(N_TALLY)) i_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap_vec),
    .clr_req (flag_clr),
    .flag    (flag)
  );

  rxerr_rdmux #(
    .N  (N_TALLY),
    .W  (TALLY_W),
    .AW (REG_AW),
    .DW (REG_DW)
  ) i_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cnts    (cnt_vec),
    .flag    (flag),
    .rd_clr  (clr_vec),
    .rd_data (rd_data)
  );

  assign ovf_irq = flag;

  AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == STAT_OFS) |=> (rd_data == (REG_DW'(ovf_irq) << OVF_BIT)) || $changed(ovf_irq)); // R8
  AST_RIPPLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec == '0 && !rd_en) |=> $stable(cnt_vec)); // R9
endmodule

// File: tb/test_rxerr_tally.sv
module test_rxerr_tally;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_crc, ev_align, ev_miss;
  logic        rd_en, wr_en;
  logic [7:0]  rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic        ovf_irq;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  rxerr_tally i_rxerr_tally (
    .clk(clk), .rst_n(rst_n),
    .ev_crc(ev_crc), .ev_align(ev_align), .ev_miss(ev_miss),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovf_irq(ovf_irq)
  );

  function automatic logic [7:0] ofs(input int k);
    return 8'h20 + 8'(4 * k);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ev(input int k, input logic v);
    case (k)
      0: ev_crc = v;
      1: ev_align = v;
      default: ev_miss = v;
    endcase
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); set_ev(k, 1'b1);
    end
    @(negedge clk); set_ev(k, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; ev_crc = 0; ev_align = 0; ev_miss = 0;
    rd_en = 0; wr_en = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 flag", {31'b0, ovf_irq}, 0);
    for (int k = 0; k < 3; k++) begin
      rd(ofs(k), d); chk("R1 tally", d, 0);
    end

    // R2 R3 R5 R6 sweep: n events per tally, expected n mod 16
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n <= 20; n++) begin
        if (n > 0) pulse(k, n);
        chk("R5 flag after sweep", {31'b0, ovf_irq}, (n >= 16) ? 1 : 0);
        rd(ofs(k), d); chk("R2 R3 tally value", d, n % 16);
        rd(ofs(k), d); chk("R3 cleared", d, 0);
        for (int j = 0; j < 3; j++)
          if (j != k) begin rd(ofs(j), d); chk("R2 other tally", d, 0); end
        wr(8'h04, 32'h200);
        chk("R6 flag cleared", {31'b0, ovf_irq}, 0);
      end
    end

    // R4 read and event together
    pulse(0, 5);
    @(negedge clk); rd_en = 1; rd_addr = ofs(0); ev_crc = 1;
    @(negedge clk); rd_en = 0; ev_crc = 0;
    chk("R4 old value", rd_data, 5);
    rd(ofs(0), d); chk("R4 becomes one", d, 1);
    pulse(1, 15);
    @(negedge clk); rd_en = 1; rd_addr = ofs(1); ev_align = 1;
    @(negedge clk); rd_en = 0; ev_align = 0;
    chk("R4 old 15", rd_data, 15);
    chk("R4 no wrap", {31'b0, ovf_irq}, 0);
    rd(ofs(1), d); chk("R4 after 15", d, 1);

    // R6 non-clearing writes, R8 status read
    pulse(2, 16);
    chk("R5 miss wrap", {31'b0, ovf_irq}, 1);
    wr(8'h04, 32'hFFFF_FDFF); chk("R6 bit9 zero", {31'b0, ovf_irq}, 1);
    wr(8'h08, 32'h200);       chk("R6 other ofs", {31'b0, ovf_irq}, 1);
    pulse(2, 3);
    rd(8'h04, d); chk("R8 status word", d, 32'h200);
    rd(ofs(2), d); chk("R8 status read clears nothing", d, 3);
    rd(8'h2C, d); chk("R8 unmapped", d, 0);
    rd(8'h00, d); chk("R8 unmapped 0", d, 0);
    wr(8'h04, 32'h200);
    chk("R6 clear", {31'b0, ovf_irq}, 0);

    // R7 wrap and clear in the same cycle
    pulse(0, 15);
    @(negedge clk); ev_crc = 1; wr_en = 1; wr_addr = 8'h04; wr_data = 32'h200;
    @(negedge clk); ev_crc = 0; wr_en = 0;
    chk("R7 set wins", {31'b0, ovf_irq}, 1);
    rd(ofs(0), d); chk("R7 tally wrapped", d, 0);
    wr(8'h04, 32'h200);

    // R9 simultaneous events
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); ev_crc = 1; ev_align = 1; ev_miss = 1;
    end
    @(negedge clk); ev_crc = 0; ev_align = 0; ev_miss = 0;
    for (int k = 0; k < 3; k++) begin
      rd(ofs(k), d); chk("R9 joint count", d, 7);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule